// File: doc/BRIEF.md
# Prescaled Pulse-Width Modulator

This block drives one pulse-width-modulated output from a single 32-bit control word. The incoming clock passes first through a programmable divider. Each divided tick steps an 8-bit phase counter, so one output period lasts 256 ticks. The output is high while the phase is below a programmed pulse width. A separate control bit holds the output high for the whole period, whatever the pulse width is. An enable bit gates the whole generator.

Software writes the whole control word in one cycle and can read it back. A write takes effect at once. It abandons the period in progress and starts a new one from phase zero on the following clock. Clearing the enable bit pulls the output low at once, without waiting for the period to end.

Top module: `pulse_mod_core`

## Requirements
- R1: A write (`wr_en` high) stores the control word. The divide value is in bits [12:0], the pulse width in bits [23:16], the force-high bit is bit 24 and the enable bit is bit 31. From the next cycle `rd_data` returns those fields in the same positions, and every other bit reads as zero.
- R2: While the synchronous reset `rst` is high at a clock edge, the control word is cleared. After that edge `rd_data` is zero and `pwm_out` is low.
- R3: While enabled, the phase counter advances by one, wrapping from 255 to 0, once every (divide value + 1) clocks. A divide value of 0 advances it on every clock.
- R4: While enabled with the force-high bit clear, `pwm_out` is high exactly when the phase is strictly less than the pulse width. A pulse width of 0 gives a constantly low output, and 255 gives a low output for one tick per 256.
- R5: While enabled with the force-high bit set, `pwm_out` is constantly high and the pulse-width field has no effect.
- R6: Any write clears the divider and the phase counter at the same clock edge. The cycle after the write starts a new period at phase 0, and the interrupted period is never completed.
- R7: While the enable bit is clear, `pwm_out` is low and both counters stay at zero. Disabling takes effect in the cycle right after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word to store |
| rd_data | output | 32 | Stored control word, unused bits zero |
| pwm_out | output | 1 | Modulated output, low when inactive |

## Verification
The bench goes after the ends of both fields.
- A divide value of 0 is the fastest rate. A divider that counted to the field value instead of to the field plus one would run each tick one clock early or late.
- A pulse width of 0 must stay low the whole time, and a design that compared with less-or-equal would give a one-tick glitch.
- The force-high bit combined with a width of 0 shows at once whether the width field still leaks through.

The bench also writes new values in the middle of a period and disables the generator mid-pulse. A design that finished the running period, or that kept its counters through a write, would then drift away from the cycle-by-cycle reference model. Writing all ones catches readback bits that should be zero.

// File: rtl/pulse_mod_pkg.sv
package pulse_mod_pkg;
    localparam int CTRL_W   = 32;
    localparam int DIV_W    = 13;
    localparam int PH_W     = 8;
    localparam int DIV_LSB  = 0;
    localparam int WID_LSB  = 16;
    localparam int FULL_BIT = 24;
    localparam int EN_BIT   = 31;

    typedef struct packed {
        logic             en;
        logic             full;
        logic [PH_W-1:0]  width;
        logic [DIV_W-1:0] div;
    } ctrl_t;

    localparam logic [CTRL_W-1:0] CTRL_MASK =
        (CTRL_W'(1) << EN_BIT) | (CTRL_W'(1) << FULL_BIT) |
        (CTRL_W'((1 << PH_W) - 1) << WID_LSB) |
        (CTRL_W'((1 << DIV_W) - 1) << DIV_LSB);
endpackage

// File: rtl/pulse_mod_cfg.sv
module pulse_mod_cfg
    import pulse_mod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [CTRL_W-1:0] wr_data_i,
    output ctrl_t             ctrl_o,
    output logic [CTRL_W-1:0] rd_data_o
);
    typedef struct packed {
        ctrl_t ctrl;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            st_d.ctrl.en    = wr_data_i[EN_BIT];
            st_d.ctrl.full  = wr_data_i[FULL_BIT];
            st_d.ctrl.width = wr_data_i[WID_LSB +: PH_W];
            st_d.ctrl.div   = wr_data_i[DIV_LSB +: DIV_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_comb begin
        rd_data_o                      = '0;
        rd_data_o[EN_BIT]              = st_q.ctrl.en;
        rd_data_o[FULL_BIT]            = st_q.ctrl.full;
        rd_data_o[WID_LSB +: PH_W]     = st_q.ctrl.width;
        rd_data_o[DIV_LSB +: DIV_W]    = st_q.ctrl.div;
    end

    assign ctrl_o = st_q.ctrl;

    // R1: a stored word reads back masked on the next cycle
    assert_readback_R1: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |=> (rd_data_o == ($past(wr_data_i) & CTRL_MASK)));
endmodule

// File: rtl/pulse_mod_presc.sv
module pulse_mod_presc #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear_i,
    input  logic         run_i,
    input  logic [W-1:0] limit_i,
    output logic         tick_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;
    logic   at_limit;

    assign at_limit = (st_q.cnt == limit_i);

    always_comb begin
        st_d = st_q;
        if (clear_i || !run_i)
            st_d.cnt = '0;
        else if (at_limit)
            st_d.cnt = '0;
        else
            st_d.cnt = st_q.cnt + {{(W-1){1'b0}}, 1'b1};
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign tick_o = run_i && !clear_i && at_limit;

    // R3: with a divide value above zero, ticks never come back to back
    assert_tick_gap_R3: assert property (@(posedge clk) disable iff (rst)
        (tick_o && (limit_i != '0)) |=> !tick_o);
endmodule

// File: rtl/pulse_mod_phase.sv
module pulse_mod_phase #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear_i,
    input  logic         run_i,
    input  logic         tick_i,
    input  logic [W-1:0] width_i,
    input  logic         full_i,
    output logic         out_o
);
    typedef struct packed {
        logic [W-1:0] phase;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i || !run_i)
            st_d.phase = '0;
        else if (tick_i)
            st_d.phase = st_q.phase + {{(W-1){1'b0}}, 1'b1};
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_o = run_i && (full_i || (st_q.phase < width_i));

    // R6: a write restarts the period at phase zero
    assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (st_q.phase == '0));

    // R3: phase moves by at most one step per clock while running
    assert_phase_step_R3: assert property (@(posedge clk) disable iff (rst)
        (run_i && !clear_i) |=>
        ((st_q.phase == $past(st_q.phase)) ||
         (st_q.phase == $past(st_q.phase) + {{(W-1){1'b0}}, 1'b1})));
endmodule

// File: rtl/pulse_mod_core.sv
module pulse_mod_core
    import pulse_mod_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        pwm_out
);
    ctrl_t ctrl;
    logic  tick;

    pulse_mod_cfg i_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .ctrl_o    (ctrl),
        .rd_data_o (rd_data)
    );

    pulse_mod_presc #(.W(DIV_W)) i_presc (
        .clk     (clk),
        .rst     (rst),
        .clear_i (wr_en),
        .run_i   (ctrl.en),
        .limit_i (ctrl.div),
        .tick_o  (tick)
    );

    pulse_mod_phase #(.W(PH_W)) i_phase (
        .clk     (clk),
        .rst     (rst),
        .clear_i (wr_en),
        .run_i   (ctrl.en),
        .tick_i  (tick),
        .width_i (ctrl.width),
        .full_i  (ctrl.full),
        .out_o   (pwm_out)
    );

    // R2: reset leaves the register clear and the output low
    assert_reset_clear_R2: assert property (@(posedge clk)
        rst |=> ((rd_data == '0) && !pwm_out));

    // R5: force-high bit keeps the output high while enabled
    assert_full_high_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_data[EN_BIT] && rd_data[FULL_BIT]) |-> pwm_out);

    // R7: disabled generator keeps the output low
    assert_off_low_R7: assert property (@(posedge clk) disable iff (rst)
        !rd_data[EN_BIT] |-> !pwm_out);
endmodule

// File: tb/test_pulse_mod_core.sv
module test_pulse_mod_core;
    localparam int          WATCHDOG = 150000;
    localparam logic [31:0] MASK     = 32'h81FF_1FFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        pwm_out;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    // reference model state
    int m_div = 0, m_width = 0, m_pcnt = 0, m_phase = 0;
    bit m_full = 0, m_en = 0;

    always #4 clk = ~clk;

    pulse_mod_core i_pulse_mod_core (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .pwm_out (pwm_out)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_div = 0; m_width = 0; m_full = 0; m_en = 0;
            m_pcnt = 0; m_phase = 0;
        end else if (wr_en) begin
            m_div   = int'(wr_data[12:0]);
            m_width = int'(wr_data[23:16]);
            m_full  = wr_data[24];
            m_en    = wr_data[31];
            m_pcnt  = 0;
            m_phase = 0;
        end else if (m_en) begin
            if (m_pcnt == m_div) begin
                m_pcnt  = 0;
                m_phase = (m_phase + 1) % 256;
            end else begin
                m_pcnt = m_pcnt + 1;
            end
        end else begin
            m_pcnt = 0;
            m_phase = 0;
        end
    end

    function automatic logic [31:0] exp_rd();
        logic [31:0] v = '0;
        v[12:0]  = 13'(m_div);
        v[23:16] = 8'(m_width);
        v[24]    = m_full;
        v[31]    = m_en;
        return v;
    endfunction

    function automatic logic exp_out();
        return m_en && (m_full || (m_phase < m_width));
    endfunction

    always @(negedge clk) begin
        if (!done) begin
            n_cmp++;
            if (rd_data !== exp_rd()) begin
                n_bad++;
                $display("FAIL R1/R2 rd_data actual=%h expected=%h at cycle %0d",
                         rd_data, exp_rd(), cyc);
            end
            n_cmp++;
            if (pwm_out !== exp_out()) begin
                n_bad++;
                if (!m_en)
                    $display("FAIL R7 pwm_out actual=%b expected=%b at cycle %0d",
                             pwm_out, exp_out(), cyc);
                else if (m_full)
                    $display("FAIL R5 pwm_out actual=%b expected=%b at cycle %0d",
                             pwm_out, exp_out(), cyc);
                else
                    $display("FAIL R3/R4/R6 pwm_out actual=%b expected=%b phase=%0d at cycle %0d",
                             pwm_out, exp_out(), m_phase, cyc);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            n_bad++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_run();
        end
    end

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] word(input bit en, input bit full,
                                         input int width, input int div);
        logic [31:0] v = '0;
        v[31]    = en;
        v[24]    = full;
        v[23:16] = 8'(width);
        v[12:0]  = 13'(div);
        return v;
    endfunction

    initial begin
        // R2: reset state
        idle(3);
        rst = 1'b0;
        idle(4);
        // R3/R4: fastest divide, half duty
        wr(word(1, 0, 128, 0));
        idle(600);
        // R3: divide by three, quarter duty
        wr(word(1, 0, 64, 2));
        idle(1600);
        // R4: width zero stays low
        wr(word(1, 0, 0, 1));
        idle(600);
        // R4: width 255, one low tick per period
        wr(word(1, 0, 255, 0));
        idle(700);
        // R5: force-high with width zero
        wr(word(1, 1, 0, 0));
        idle(300);
        // R6: rewrite mid-period, running period abandoned
        wr(word(1, 0, 200, 1));
        idle(150);
        wr(word(1, 0, 100, 0));
        idle(50);
        wr(word(1, 0, 100, 0));
        idle(400);
        // R7: disable in the middle of a pulse
        wr(word(1, 0, 250, 3));
        idle(100);
        wr(word(0, 0, 250, 3));
        idle(200);
        // R7: disabled with force-high still low; R1 all ones masked
        wr(word(0, 1, 255, 5));
        idle(50);
        wr(32'hFFFF_FFFF);
        idle(20000);
        // R1: unused bits only
        wr(~MASK);
        idle(20);
        // R6: re-enable starts from phase zero
        wr(word(1, 0, 3, 4));
        idle(3000);
        // R2: reset during a running period
        @(negedge clk);
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        idle(50);
        finish_run();
    end
endmodule